// File: doc/BRIEF.md
# SPI Master Register Front End with FIFOs and Watermarks

This block is the software-facing side of an SPI master. It decodes a simple 32-bit register bus at fixed byte offsets. It holds the configuration fields that a separate serial engine reads, such as the clock divider, clock mode, chip-select settings, delays and frame format.

Two FIFOs sit between the bus and the serial engine. Software pushes transmit words, and the engine pulls them through a valid/ready pair. The engine pushes received words with a valid strobe, and software pops them by reading the receive data register. Bit 31 of each data register reports the FIFO state, so software can poll a single word.

Two watermark thresholds produce level-type pending bits. An enable mask gates these onto a single interrupt line. A flash-interface control register exists at its offset, but its enable bit always reads 0, so the controller stays in plain register mode.

Top module: `spi_regif`

## Requirements
- R1: After reset the TX mark (0x50) reads 1, the RX mark (0x54) reads 0, the interrupt enable (0x70) reads 0, the divider (0x00) reads 3, the CS idle levels (0x14) read all ones, and the format register (0x40) reads 0x00080000 (frame length 8 in bits 19:16).
- R2: A read of the TX data register (0x48) returns bit 31 = 1 exactly when the transmit FIFO holds DEPTH words, and bits 30:0 = 0.
- R3: A write to 0x48 pushes wdata[7:0] into the transmit FIFO. `tx_valid` is high while the FIFO is non-empty, `tx_data` shows the oldest word, and the word leaves on a cycle with `tx_ready` high, in write order.
- R4: A write to 0x48 while the transmit FIFO is full is dropped and never reaches `tx_data`.
- R5: A read of the RX data register (0x4C) with words present returns the oldest word in bits 7:0, returns bit 31 = 0, and removes that word.
- R6: A read of 0x4C with the receive FIFO empty returns 0x80000000 and removes nothing.
- R7: A word offered on `rx_valid` while the receive FIFO is full is discarded.
- R8: Pending bit 0 (0x74) is 1 while the transmit FIFO count is strictly below the TX mark.
- R9: Pending bit 1 (0x74) is 1 while the receive FIFO count is strictly above the RX mark.
- R10: `irq` equals the OR over bits 1:0 of (pending AND enable), and writes to the pending register (0x74) change nothing.
- R11: Bit 0 of the flash control register (0x60) always reads 0, even after a write of 1.
- R12: Configuration registers keep only their defined bits and drive the matching `cfg_*` ports. The divider keeps bits 11:0, the CS index keeps log2(NCS) bits, and the format keeps lanes [1:0], LSB-first [2], transmit-only [3] and frame length [19:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the access |
| irq | output | 1 | Masked watermark interrupt |
| tx_valid | output | 1 | Transmit FIFO has a word for the engine |
| tx_ready | input | 1 | Engine takes the word on `tx_data` |
| tx_data | output | DATA_W | Oldest transmit word |
| rx_valid | input | 1 | Engine delivers a received word |
| rx_data | input | DATA_W | Received word |
| cfg_div | output | 12 | Serial clock divider |
| cfg_clk_mode | output | 2 | Clock phase [0] and polarity [1] |
| cfg_cs_index | output | CSW | Selected chip-select line |
| cfg_cs_idle | output | NCS | Inactive level of each chip select |
| cfg_cs_mode | output | 2 | Chip-select control mode |
| cfg_lead_dly | output | 8 | CS-assert to first clock delay |
| cfg_trail_dly | output | 8 | Last clock to CS-release delay |
| cfg_gap_cs | output | 8 | Minimum CS inactive time |
| cfg_gap_word | output | 8 | Gap between words |
| cfg_lanes | output | 2 | Data lanes: 0 single, 1 dual, 2 quad |
| cfg_lsb_first | output | 1 | Bit order |
| cfg_tx_only | output | 1 | Received data is not stored when set |
| cfg_frame_len | output | 4 | Bits per frame |

## Verification
The bench builds the block with DEPTH = 5, NCS = 4 and DATA_W = 8. A depth that is not a power of two selects the explicit pointer-wrap variant of the FIFO. The depth is small enough that random traffic hits full and empty on both FIFOs often, and it wraps the pointers many times. Four chip selects give a 2-bit index, so the R12 masking check truncates a written value of 7. The 3-bit mark fields can be set both below and above every reachable count.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
   localparam logic [7:0] A_DIV    = 8'h00;
   localparam logic [7:0] A_CLKM   = 8'h04;
   localparam logic [7:0] A_CSIX   = 8'h10;
   localparam logic [7:0] A_CSIDLE = 8'h14;
   localparam logic [7:0] A_CSMODE = 8'h18;
   localparam logic [7:0] A_DLY0   = 8'h28;
   localparam logic [7:0] A_DLY1   = 8'h2C;
   localparam logic [7:0] A_FMT    = 8'h40;
   localparam logic [7:0] A_TXD    = 8'h48;
   localparam logic [7:0] A_RXD    = 8'h4C;
   localparam logic [7:0] A_TXMK   = 8'h50;
   localparam logic [7:0] A_RXMK   = 8'h54;
   localparam logic [7:0] A_FLCTL  = 8'h60;
   localparam logic [7:0] A_FLFMT  = 8'h64;
   localparam logic [7:0] A_IEN    = 8'h70;
   localparam logic [7:0] A_IPEND  = 8'h74;
   localparam int         FLAG_BIT = 31;
   localparam int         PEND_TX  = 0;
   localparam int         PEND_RX  = 1;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
   parameter  int DEPTH = 8,
   parameter  int W     = 8,
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("spi_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_n, rp_n;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_wrap
         assign wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push_ok) wp <= wp_n;
         if (pop_ok)  rp <= rp_n;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop) |=> (count == $past(count) + 1'b1));

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> full);
endmodule

// File: rtl/spi_cfgregs.sv
module spi_cfgregs
   import spi_regif_pkg::*;
#(
   parameter  int NCS = 4,
   localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [7:0]     addr,
   input  logic [31:0]    wdata,
   output logic [31:0]    rd_val,
   output logic [11:0]    div,
   output logic [1:0]     clk_mode,
   output logic [CSW-1:0] cs_index,
   output logic [NCS-1:0] cs_idle,
   output logic [1:0]     cs_mode,
   output logic [7:0]     lead_dly,
   output logic [7:0]     trail_dly,
   output logic [7:0]     gap_cs,
   output logic [7:0]     gap_word,
   output logic [1:0]     lanes,
   output logic           lsb_first,
   output logic           tx_only,
   output logic [3:0]     frame_len
);
   logic [31:0] fl_fmt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div       <= 12'd3;
         clk_mode  <= '0;
         cs_index  <= '0;
         cs_idle   <= '1;
         cs_mode   <= '0;
         lead_dly  <= 8'd1;
         trail_dly <= 8'd1;
         gap_cs    <= 8'd1;
         gap_word  <= '0;
         lanes     <= '0;
         lsb_first <= 1'b0;
         tx_only   <= 1'b0;
         frame_len <= 4'd8;
         fl_fmt    <= '0;
      end else if (wr) begin
         case (addr)
            A_DIV:    div      <= wdata[11:0];
            A_CLKM:   clk_mode <= wdata[1:0];
            A_CSIX:   cs_index <= wdata[CSW-1:0];
            A_CSIDLE: cs_idle  <= wdata[NCS-1:0];
            A_CSMODE: cs_mode  <= wdata[1:0];
            A_DLY0: begin
               lead_dly  <= wdata[7:0];
               trail_dly <= wdata[23:16];
            end
            A_DLY1: begin
               gap_cs   <= wdata[7:0];
               gap_word <= wdata[23:16];
            end
            A_FMT: begin
               lanes     <= wdata[1:0];
               lsb_first <= wdata[2];
               tx_only   <= wdata[3];
               frame_len <= wdata[19:16];
            end
            A_FLFMT:  fl_fmt <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      rd_val = '0;
      case (addr)
         A_DIV:    rd_val[11:0]    = div;
         A_CLKM:   rd_val[1:0]     = clk_mode;
         A_CSIX:   rd_val[CSW-1:0] = cs_index;
         A_CSIDLE: rd_val[NCS-1:0] = cs_idle;
         A_CSMODE: rd_val[1:0]     = cs_mode;
         A_DLY0:   rd_val          = {8'h00, trail_dly, 8'h00, lead_dly};
         A_DLY1:   rd_val          = {8'h00, gap_word, 8'h00, gap_cs};
         A_FMT:    rd_val          = {12'h000, frame_len, 12'h000, tx_only, lsb_first, lanes};
         A_FLFMT:  rd_val          = fl_fmt;
         default:  rd_val          = '0;
      endcase
   end
endmodule

// File: rtl/spi_wmark.sv
module spi_wmark
   import spi_regif_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [7:0]    addr,
   input  logic [CW-1:0] wdata,
   input  logic [CW-1:0] tx_count,
   input  logic [CW-1:0] rx_count,
   output logic [1:0]    pend,
   output logic          irq,
   output logic [31:0]   rd_val
);
   logic [CW-1:0] tx_mark, rx_mark;
   logic [1:0]    ien;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_mark <= CW'(1);
         rx_mark <= '0;
         ien     <= '0;
      end else if (wr) begin
         case (addr)
            A_TXMK: tx_mark <= wdata;
            A_RXMK: rx_mark <= wdata;
            A_IEN:  ien     <= wdata[1:0];
            default: ;
         endcase
      end
   end

   assign pend[PEND_TX] = (tx_count < tx_mark);
   assign pend[PEND_RX] = (rx_count > rx_mark);
   assign irq           = |(pend & ien);

   always_comb begin
      rd_val = '0;
      case (addr)
         A_TXMK:  rd_val[CW-1:0] = tx_mark;
         A_RXMK:  rd_val[CW-1:0] = rx_mark;
         A_IEN:   rd_val[1:0]    = ien;
         A_IPEND: rd_val[1:0]    = pend;
         default: rd_val         = '0;
      endcase
   end

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 2'b00) |-> !irq);

   // R8
   tx_empty_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0 && tx_mark != '0) |-> pend[PEND_TX]);
endmodule

// File: rtl/spi_regif.sv
module spi_regif
   import spi_regif_pkg::*;
#(
   parameter  int DEPTH  = 8,
   parameter  int DATA_W = 8,
   parameter  int NCS    = 4,
   localparam int CW     = $clog2(DEPTH + 1),
   localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic [11:0]       cfg_div,
   output logic [1:0]        cfg_clk_mode,
   output logic [CSW-1:0]    cfg_cs_index,
   output logic [NCS-1:0]    cfg_cs_idle,
   output logic [1:0]        cfg_cs_mode,
   output logic [7:0]        cfg_lead_dly,
   output logic [7:0]        cfg_trail_dly,
   output logic [7:0]        cfg_gap_cs,
   output logic [7:0]        cfg_gap_word,
   output logic [1:0]        cfg_lanes,
   output logic              cfg_lsb_first,
   output logic              cfg_tx_only,
   output logic [3:0]        cfg_frame_len
);
   generate
      if (DATA_W < 1 || DATA_W > FLAG_BIT) begin : g_bad_width
         $error("spi_regif: DATA_W must be 1..31 to leave room for the flag bit");
      end
      if (NCS < 1 || NCS > 32) begin : g_bad_ncs
         $error("spi_regif: NCS must be 1..32");
      end
      if (CW > 8) begin : g_bad_depth
         $error("spi_regif: DEPTH too large for the mark fields");
      end
   endgenerate

   logic              wr_en, rd_en, tx_push, rx_pop;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [CW-1:0]     tx_count, rx_count;
   logic [DATA_W-1:0] rx_head;
   logic [31:0]       cfg_rd, wm_rd, fifo_rd;
   logic [1:0]        pend;

   assign wr_en   = bus_sel && bus_wr;
   assign rd_en   = bus_sel && !bus_wr;
   assign tx_push = wr_en && (bus_addr == A_TXD);
   assign rx_pop  = rd_en && (bus_addr == A_RXD);

   spi_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
      .pop(tx_ready), .rdata(tx_data),
      .full(tx_full), .empty(tx_empty), .count(tx_count)
   );

   spi_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_valid), .wdata(rx_data),
      .pop(rx_pop), .rdata(rx_head),
      .full(rx_full), .empty(rx_empty), .count(rx_count)
   );

   assign tx_valid = !tx_empty;

   spi_cfgregs #(.NCS(NCS)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr(wr_en), .addr(bus_addr), .wdata(bus_wdata),
      .rd_val(cfg_rd), .div(cfg_div), .clk_mode(cfg_clk_mode),
      .cs_index(cfg_cs_index), .cs_idle(cfg_cs_idle), .cs_mode(cfg_cs_mode),
      .lead_dly(cfg_lead_dly), .trail_dly(cfg_trail_dly),
      .gap_cs(cfg_gap_cs), .gap_word(cfg_gap_word),
      .lanes(cfg_lanes), .lsb_first(cfg_lsb_first), .tx_only(cfg_tx_only),
      .frame_len(cfg_frame_len)
   );

   spi_wmark #(.CW(CW)) i_wm (
      .clk(clk), .rst_n(rst_n), .wr(wr_en), .addr(bus_addr),
      .wdata(bus_wdata[CW-1:0]), .tx_count(tx_count), .rx_count(rx_count),
      .pend(pend), .irq(irq), .rd_val(wm_rd)
   );

   always_comb begin
      fifo_rd = '0;
      if (bus_addr == A_TXD) begin
         fifo_rd[FLAG_BIT] = tx_full;
      end else if (bus_addr == A_RXD) begin
         if (rx_empty) fifo_rd[FLAG_BIT] = 1'b1;
         else          fifo_rd[DATA_W-1:0] = rx_head;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_en) bus_rdata <= fifo_rd | cfg_rd | wm_rd;
   end

   // R6
   rx_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && rx_empty) |=> (bus_rdata == 32'h8000_0000));

   // R5
   rx_pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_empty) |=> !bus_rdata[FLAG_BIT]);

   // R7
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full && !rx_pop) |=> (rx_count == $past(rx_count)));

   // R11
   flash_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && bus_addr == A_FLCTL) |=> !bus_rdata[0]);

   // R2
   tx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && bus_addr == A_TXD) |=> (bus_rdata[30:0] == '0));
endmodule

// File: tb/test_spi_regif.sv
`timescale 1ns/1ps
module test_spi_regif;
   localparam int DEPTH = 5;
   localparam int DW    = 8;
   localparam int NCS   = 4;
   localparam int CSW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq, tx_valid;
   logic tx_ready = 1'b0;
   logic [DW-1:0] tx_data;
   logic rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [11:0] cfg_div;
   logic [1:0]  cfg_clk_mode, cfg_cs_mode, cfg_lanes;
   logic [CSW-1:0] cfg_cs_index;
   logic [NCS-1:0] cfg_cs_idle;
   logic [7:0] cfg_lead_dly, cfg_trail_dly, cfg_gap_cs, cfg_gap_word;
   logic cfg_lsb_first, cfg_tx_only;
   logic [3:0] cfg_frame_len;

   always #10 clk = ~clk;

   spi_regif #(.DEPTH(DEPTH), .DATA_W(DW), .NCS(NCS)) i_spi_regif (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .cfg_div(cfg_div), .cfg_clk_mode(cfg_clk_mode), .cfg_cs_index(cfg_cs_index),
      .cfg_cs_idle(cfg_cs_idle), .cfg_cs_mode(cfg_cs_mode),
      .cfg_lead_dly(cfg_lead_dly), .cfg_trail_dly(cfg_trail_dly),
      .cfg_gap_cs(cfg_gap_cs), .cfg_gap_word(cfg_gap_word),
      .cfg_lanes(cfg_lanes), .cfg_lsb_first(cfg_lsb_first),
      .cfg_tx_only(cfg_tx_only), .cfg_frame_len(cfg_frame_len)
   );

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [7:0] txq[$];
   logic [7:0] rxq[$];
   int txm = 1, rxm = 0;
   logic [1:0] ienm = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_pend(input int txc, input int rxc, input int tm, input int rm);
      return {30'd0, rxc > rm, txc < tm};
   endfunction

   task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bread(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic eng_take(input string req);
      logic [7:0] e;
      chk(tx_valid == (txq.size() != 0), req, 32'(tx_valid), 32'(txq.size() != 0));
      if (txq.size() != 0) begin
         e = txq.pop_front();
         chk(tx_data == e, req, 32'(tx_data), 32'(e));
      end
      tx_ready = 1'b1;
      @(posedge clk); #1;
      tx_ready = 1'b0;
   endtask

   task automatic eng_give(input logic [7:0] d);
      rx_valid = 1'b1; rx_data = d;
      @(posedge clk); #1;
      rx_valid = 1'b0;
      if (rxq.size() < DEPTH) rxq.push_back(d);
   endtask

   task automatic rx_read_chk(input string req);
      logic [31:0] r, e;
      e = (rxq.size() == 0) ? 32'h8000_0000 : 32'(rxq.pop_front());
      bread(8'h4C, r);
      chk(r == e, req, r, e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset values
      bread(8'h50, r); chk(r == 32'd1, "R1 txmark", r, 32'd1);
      bread(8'h54, r); chk(r == 32'd0, "R1 rxmark", r, 32'd0);
      bread(8'h70, r); chk(r == 32'd0, "R1 ien", r, 32'd0);
      bread(8'h00, r); chk(r == 32'd3, "R1 div", r, 32'd3);
      bread(8'h14, r); chk(r == 32'hF, "R1 csidle", r, 32'hF);
      bread(8'h40, r); chk(r == 32'h0008_0000, "R1 fmt", r, 32'h0008_0000);
      chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
      // R8 pending at reset: count 0 < mark 1
      bread(8'h74, r); chk(r == 32'h1, "R8 reset pend", r, 32'h1);

      // R12 masking and cfg ports
      bwrite(8'h00, 32'hFFFF_FFFF);
      bread(8'h00, r); chk(r == 32'hFFF, "R12 div", r, 32'hFFF);
      chk(cfg_div == 12'hFFF, "R12 cfg_div", 32'(cfg_div), 32'hFFF);
      bwrite(8'h10, 32'd7);
      bread(8'h10, r); chk(r == 32'd3, "R12 csix", r, 32'd3);
      chk(cfg_cs_index == 2'd3, "R12 cfg_cs_index", 32'(cfg_cs_index), 3);
      bwrite(8'h40, 32'hFFFF_FFFF);
      bread(8'h40, r); chk(r == 32'h000F_000F, "R12 fmt", r, 32'h000F_000F);
      chk({cfg_frame_len, cfg_tx_only, cfg_lsb_first, cfg_lanes} == 8'hFF, "R12 cfg_fmt",
          32'({cfg_frame_len, cfg_tx_only, cfg_lsb_first, cfg_lanes}), 32'hFF);
      bwrite(8'h28, 32'h0012_0034);
      chk(cfg_lead_dly == 8'h34 && cfg_trail_dly == 8'h12, "R12 dly0",
          32'({cfg_trail_dly, cfg_lead_dly}), 32'h1234);
      bwrite(8'h40, 32'h0008_0000);

      // R11 flash control enable held low
      bwrite(8'h60, 32'h1);
      bread(8'h60, r); chk(r[0] == 1'b0, "R11 flash ctl", r, 0);

      // R10 pending read-only, irq masking
      bwrite(8'h74, 32'h0);
      bread(8'h74, r); chk(r == 32'h1, "R10 pend ro", r, 32'h1);
      bwrite(8'h70, 32'h1); ienm = 2'b01;
      chk(irq == 1'b1, "R10 irq on", 32'(irq), 1);
      bwrite(8'h70, 32'h2); ienm = 2'b10;
      chk(irq == 1'b0, "R10 irq masked", 32'(irq), 0);

      // R2/R3/R4 fill, overflow, drain
      for (int i = 0; i < DEPTH; i++) begin
         bread(8'h48, r); chk(r == 32'h0, "R2 not full", r, 0);
         bwrite(8'h48, 32'hA0 + 32'(i)); txq.push_back(8'hA0 + 8'(i));
      end
      bread(8'h48, r); chk(r == 32'h8000_0000, "R2 full", r, 32'h8000_0000);
      bwrite(8'h48, 32'hEE);
      for (int i = 0; i < DEPTH; i++) eng_take("R4/R3 drain order");
      chk(tx_valid == 1'b0, "R3 empty", 32'(tx_valid), 0);

      // R5/R6/R7 receive path
      rx_read_chk("R6 empty read");
      for (int i = 0; i < DEPTH + 1; i++) eng_give(8'h50 + 8'(i));
      for (int i = 0; i < DEPTH; i++) rx_read_chk("R5/R7 rx order");
      rx_read_chk("R6 empty after drain");

      // R9 rx watermark
      bwrite(8'h54, 32'd2); rxm = 2;
      eng_give(8'h11); eng_give(8'h22);
      bread(8'h74, r); chk(r[1] == 1'b0, "R9 at mark", r, 0);
      eng_give(8'h33);
      bread(8'h74, r); chk(r[1] == 1'b1, "R9 above mark", r, 32'h2);
      bwrite(8'h70, 32'h2); ienm = 2'b10;
      chk(irq == 1'b1, "R10 rx irq", 32'(irq), 1);

      // random traffic
      for (int n = 0; n < 1500; n++) begin
         int op;
         logic [31:0] e;
         op = int'($urandom_range(0, 7));
         case (op)
            0, 1: begin
               logic [7:0] d;
               d = 8'($urandom);
               bwrite(8'h48, {24'($urandom), d});
               if (txq.size() < DEPTH) txq.push_back(d);
            end
            2: eng_take("R3 random tx");
            3: eng_give(8'($urandom));
            4: rx_read_chk("R5 random rx");
            5: begin
               e = (txq.size() == DEPTH) ? 32'h8000_0000 : 32'h0;
               bread(8'h48, r); chk(r == e, "R2 random flag", r, e);
            end
            6: begin
               e = exp_pend(txq.size(), rxq.size(), txm, rxm);
               bread(8'h74, r); chk(r == e, "R8/R9 random pend", r, e);
               chk(irq == |(e[1:0] & ienm), "R10 random irq", 32'(irq), 32'(|(e[1:0] & ienm)));
            end
            default: begin
               int k;
               k = int'($urandom_range(0, 2));
               if (k == 0) begin txm = int'($urandom_range(0, 7)); bwrite(8'h50, 32'(txm)); end
               else if (k == 1) begin rxm = int'($urandom_range(0, 7)); bwrite(8'h54, 32'(rxm)); end
               else begin ienm = 2'($urandom); bwrite(8'h70, 32'(ienm)); end
            end
         endcase
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule